// File: doc/BRIEF.md
# Shared Free-Running Timer with Per-Context Compare Interrupts

This block holds one 64-bit time base that advances by one on every clock and is shared by several processor contexts. A bus master reaches it through a small 32-bit register port. The counter can be read or loaded one 32-bit half at a time, and a configuration bit freezes it. A read-only field reports the counter width and the number of interrupt sources of the system.

Every context owns a 64-bit compare value. When the shared count is at or above a context's compare value, that context's interrupt line goes high and stays high until software writes either half of that compare value. Reading the counter is made safe across the halves: reading the low half captures the high half, and a later read of the high half returns that captured value.

The port is a plain register interface with address, write enable, read strobe, write data and registered read data. Read data appears in the cycle after the strobe.

Top module: `glb_timer`

## Requirements
- R1: After synchronous reset the counter is zero and running, every compare value is all ones, the captured high half is zero, and every interrupt line is low.
- R2: While the freeze bit is clear and no counter half is written, the counter rises by exactly one per clock and carries from the low half into the high half.
- R3: Bit 28 of the configuration word at address 0x0000 freezes the counter while set. The bit is writable and reads back. A write to it takes effect from the following cycle, so the increment at the edge of the write itself still happens.
- R4: Configuration bits 27:24 read 8 (the width code (64-32)/4), and bits 23:16 read the interrupt source count (24 by default). Both fields ignore writes, and all other configuration bits read zero.
- R5: A write to address 0x0010 loads the low half, and a write to 0x0014 loads the high half. In the next cycle the counter holds the written half and the other half is unchanged. Counting then resumes from that value unless the counter is frozen.
- R6: A read is requested by raising bus_rd with an address, and bus_rdata carries the result from the next cycle on. A read of 0x0010 returns the low half as it was in the request cycle and captures the high half. A read of 0x0014 returns the captured high half.
- R7: Context c has its compare low half at 0x8000 + c*0x100 + 0xA0 and its high half at +0xA4. Both halves are writable and read back, and each context drives only its own interrupt line irq[c].
- R8: irq[c] rises in the cycle after a cycle in which counter >= compare of context c. It then stays high, even if the counter is later loaded below the compare value, until that compare value is written.
- R9: A write to either compare half of context c forces irq[c] low in the next cycle, even when a match is present in the write cycle. If the counter is still at or above the new value, irq[c] rises again one cycle later.
- R10: When a counter half is written in the same cycle as an increment would occur, the write wins. A counter read in the same cycle as a counter write returns the value from before the write.
- R11: Reads of unmapped addresses return zero, and writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Byte address of the register |
| bus_we | input | 1 | Write enable for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | NUM_CTX | Compare interrupt, one per context |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a compare write and a live match on the same context. The bench provokes it by stopping the counter above an already-met compare value and rewriting the compare while the match still holds, and it judges the line as low for exactly one cycle and then high again. The second pair is a counter load and either an increment or a counter read. Here a write and a read of the low half are issued together, and the read is expected to return the pre-write value while the following read returns the loaded one. Random traffic that sets compare values a few counts ahead of the running counter keeps both collisions occurring while a bench model tracks every line and every read.

// File: rtl/glb_timer_pkg.sv
package glb_timer_pkg;

    localparam int CNT_W     = 64;
    localparam int HALF_W    = 32;
    localparam int ADDR_W    = 16;
    localparam int CTX_IDX_W = ADDR_W - 9;
    localparam int STOP_BIT  = 28;
    localparam logic [3:0] WIDTH_CODE = 4'((CNT_W - 32) / 4);

    localparam logic [ADDR_W-1:0] A_CFG    = 16'h0000;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 16'h0010;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 16'h0014;
    localparam logic [7:0]        A_CMP_LO_OFS = 8'hA0;
    localparam logic [7:0]        A_CMP_HI_OFS = 8'hA4;

    typedef struct packed {
        logic cfg;
        logic cnt_lo;
        logic cnt_hi;
    } gsel_t;

endpackage

// File: rtl/glb_timer_decode.sv
module glb_timer_decode
    import glb_timer_pkg::*;
#(
    parameter int NUM_CTX = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    output gsel_t              gsel,
    output logic [NUM_CTX-1:0] cmp_lo,
    output logic [NUM_CTX-1:0] cmp_hi
);

    logic                 ctx_space;
    logic [CTX_IDX_W-1:0] ctx_idx;
    logic [7:0]           ctx_ofs;

    always_comb begin
        ctx_space   = addr[ADDR_W-1];
        ctx_idx     = addr[ADDR_W-2:8];
        ctx_ofs     = addr[7:0];
        gsel.cfg    = (addr == A_CFG);
        gsel.cnt_lo = (addr == A_CNT_LO);
        gsel.cnt_hi = (addr == A_CNT_HI);
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx_dec
        assign cmp_lo[c] = ctx_space && (ctx_idx == CTX_IDX_W'(c)) && (ctx_ofs == A_CMP_LO_OFS);
        assign cmp_hi[c] = ctx_space && (ctx_idx == CTX_IDX_W'(c)) && (ctx_ofs == A_CMP_HI_OFS);
    end

endmodule

// File: rtl/glb_timer_count.sv
module glb_timer_count
    import glb_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_cfg,
    input  logic              rd_lo,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              stop,
    output logic [HALF_W-1:0] shadow_hi
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              stop;
        logic [HALF_W-1:0] shadow;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_lo) begin
            st_d.shadow = st_q.cnt[CNT_W-1:HALF_W];
        end
        if (wr_cfg) begin
            st_d.stop = wdata[STOP_BIT];
        end
        if (wr_lo) begin
            st_d.cnt = {st_q.cnt[CNT_W-1:HALF_W], wdata};
        end else if (wr_hi) begin
            st_d.cnt = {wdata, st_q.cnt[HALF_W-1:0]};
        end else if (!st_q.stop) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt       = st_q.cnt;
    assign stop      = st_q.stop;
    assign shadow_hi = st_q.shadow;

endmodule

// File: rtl/glb_timer_match.sv
module glb_timer_match
    import glb_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  cmp,
    output logic              irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             irq;
    } match_state_t;

    match_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            st_d.cmp = {st_q.cmp[CNT_W-1:HALF_W], wdata};
        end
        if (wr_hi) begin
            st_d.cmp = {wdata, st_q.cmp[HALF_W-1:0]};
        end
        if (wr_lo || wr_hi) begin
            st_d.irq = 1'b0;
        end else if (cnt >= st_q.cmp) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cmp <= '1;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp = st_q.cmp;
    assign irq = st_q.irq;

endmodule

// File: rtl/glb_timer.sv
module glb_timer
    import glb_timer_pkg::*;
#(
    parameter int NUM_CTX = 2,
    parameter int NUM_IRQ = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        bus_addr,
    input  logic               bus_we,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CTX-1:0] irq
);

    localparam logic [7:0] IRQ_CODE = 8'(NUM_IRQ);

    typedef struct packed {
        logic [HALF_W-1:0] rdata;
    } rd_state_t;

    gsel_t                          gsel;
    logic [NUM_CTX-1:0]             cmp_lo_sel, cmp_hi_sel;
    logic [CNT_W-1:0]               cnt_w;
    logic                           stop_w;
    logic [HALF_W-1:0]              shadow_w;
    logic [NUM_CTX-1:0][CNT_W-1:0]  cmp_val;
    logic [HALF_W-1:0]              cfg_word;
    rd_state_t                      rd_d, rd_q;

    glb_timer_decode #(.NUM_CTX(NUM_CTX)) u_dec (
        .addr   (bus_addr),
        .gsel   (gsel),
        .cmp_lo (cmp_lo_sel),
        .cmp_hi (cmp_hi_sel)
    );

    glb_timer_count u_cnt (
        .clk       (clk),
        .rst       (rst),
        .wr_lo     (bus_we && gsel.cnt_lo),
        .wr_hi     (bus_we && gsel.cnt_hi),
        .wr_cfg    (bus_we && gsel.cfg),
        .rd_lo     (bus_rd && gsel.cnt_lo),
        .wdata     (bus_wdata),
        .cnt       (cnt_w),
        .stop      (stop_w),
        .shadow_hi (shadow_w)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        glb_timer_match u_match (
            .clk   (clk),
            .rst   (rst),
            .wr_lo (bus_we && cmp_lo_sel[c]),
            .wr_hi (bus_we && cmp_hi_sel[c]),
            .wdata (bus_wdata),
            .cnt   (cnt_w),
            .cmp   (cmp_val[c]),
            .irq   (irq[c])
        );
    end

    always_comb begin
        cfg_word = '0;
        cfg_word[STOP_BIT]  = stop_w;
        cfg_word[27:24]     = WIDTH_CODE;
        cfg_word[23:16]     = IRQ_CODE;

        rd_d = rd_q;
        if (bus_rd) begin
            rd_d.rdata = '0;
            if (gsel.cfg)    rd_d.rdata = cfg_word;
            if (gsel.cnt_lo) rd_d.rdata = cnt_w[HALF_W-1:0];
            if (gsel.cnt_hi) rd_d.rdata = shadow_w;
            for (int c = 0; c < NUM_CTX; c++) begin
                if (cmp_lo_sel[c]) rd_d.rdata = cmp_val[c][HALF_W-1:0];
                if (cmp_hi_sel[c]) rd_d.rdata = cmp_val[c][CNT_W-1:HALF_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

endmodule

// File: rtl/glb_timer_chk.sv
module glb_timer_chk
    import glb_timer_pkg::*;
#(
    parameter int NUM_CTX = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [15:0]        bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic [CNT_W-1:0]   cnt,
    input logic               stop,
    input logic [NUM_CTX-1:0] irq
);

    logic cnt_wr, lo_wr, cmp0_wr;

    always_comb begin
        lo_wr   = bus_we && (bus_addr == A_CNT_LO);
        cnt_wr  = lo_wr || (bus_we && (bus_addr == A_CNT_HI));
        cmp0_wr = bus_we && ((bus_addr == 16'h8000 + 16'(A_CMP_LO_OFS)) ||
                             (bus_addr == 16'h8000 + 16'(A_CMP_HI_OFS)));
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!stop && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (stop && !cnt_wr) |=> $stable(cnt));

    assert_lo_load_R5: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> (cnt[HALF_W-1:0] == $past(bus_wdata)));

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq[0] && !cmp0_wr) |=> irq[0]);

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
        cmp0_wr |=> !irq[0]);

endmodule

bind glb_timer glb_timer_chk #(.NUM_CTX(NUM_CTX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_w),
    .stop      (stop_w),
    .irq       (irq)
);

// File: tb/tb_glb_timer.sv
module tb_glb_timer;
    import glb_timer_pkg::*;

    localparam int NCTX = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [15:0]     bus_addr = '0;
    logic            bus_we = 1'b0;
    logic            bus_rd = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCTX-1:0] irq;

    int total = 0;
    int bad   = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    glb_timer #(.NUM_CTX(NCTX), .NUM_IRQ(24)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // expected-value model built from the requirements
    logic [63:0] m_cnt, m_shadow_src;
    logic [31:0] m_shadow, m_rdata;
    logic        m_stop, m_rv;
    logic [63:0] m_cmp [NCTX];
    logic [NCTX-1:0] m_irq;
    string       m_tag;

    function automatic logic [15:0] cmp_addr(int c, bit hi);
        return 16'h8000 + 16'(c * 256) + (hi ? 16'h00A4 : 16'h00A0);
    endfunction

    function automatic logic [31:0] cfg_exp(logic s);
        return {3'b000, s, 4'd8, 8'd24, 16'h0000};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_stop <= 1'b0; m_shadow <= '0; m_rv <= 1'b0; m_rdata <= '0;
            for (int c = 0; c < NCTX; c++) begin m_cmp[c] <= '1; m_irq[c] <= 1'b0; end
        end else begin
            m_rv <= bus_rd;
            if (bus_rd) begin
                m_rdata <= 32'h0; m_tag <= "R11";
                if (bus_addr == 16'h0000) begin m_rdata <= cfg_exp(m_stop); m_tag <= "R4"; end
                if (bus_addr == 16'h0010) begin m_rdata <= m_cnt[31:0]; m_shadow <= m_cnt[63:32]; m_tag <= "R6"; end
                if (bus_addr == 16'h0014) begin m_rdata <= m_shadow; m_tag <= "R6"; end
                for (int c = 0; c < NCTX; c++) begin
                    if (bus_addr == cmp_addr(c, 0)) begin m_rdata <= m_cmp[c][31:0]; m_tag <= "R7"; end
                    if (bus_addr == cmp_addr(c, 1)) begin m_rdata <= m_cmp[c][63:32]; m_tag <= "R7"; end
                end
            end
            if (bus_we && bus_addr == 16'h0010)      m_cnt <= {m_cnt[63:32], bus_wdata};
            else if (bus_we && bus_addr == 16'h0014) m_cnt <= {bus_wdata, m_cnt[31:0]};
            else if (!m_stop)                        m_cnt <= m_cnt + 64'd1;
            if (bus_we && bus_addr == 16'h0000) m_stop <= bus_wdata[28];
            for (int c = 0; c < NCTX; c++) begin
                if (bus_we && bus_addr == cmp_addr(c, 0)) begin
                    m_cmp[c][31:0] <= bus_wdata; m_irq[c] <= 1'b0;
                end else if (bus_we && bus_addr == cmp_addr(c, 1)) begin
                    m_cmp[c][63:32] <= bus_wdata; m_irq[c] <= 1'b0;
                end else if (m_cnt >= m_cmp[c]) begin
                    m_irq[c] <= 1'b1;
                end
            end
        end
    end

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // continuous comparison against the model (R6, R7, R8, R9)
    always @(negedge clk) begin
        if (!rst && chk_on && !done) begin
            for (int c = 0; c < NCTX; c++)
                check(irq[c] == m_irq[c], "R8/R9 irq line", 64'(irq[c]), 64'(m_irq[c]));
            if (m_rv) check(bus_rdata == m_rdata, m_tag, 64'(bus_rdata), 64'(m_rdata));
        end
    end

    task automatic op(bit we, bit rd, logic [15:0] a, logic [31:0] d);
        bus_we = we; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) op(0, 0, 16'h0000, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v1;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;

        // R1 reset state
        check(irq == '0, "R1 irq after reset", 64'(irq), 64'h0);
        op(0, 1, 16'h0000, 0);
        check(bus_rdata == 32'h0818_0000, "R4 config reset", 64'(bus_rdata), 64'h0818_0000);
        op(0, 1, cmp_addr(0, 0), 0);
        check(bus_rdata == 32'hFFFF_FFFF, "R1 compare reset", 64'(bus_rdata), 64'hFFFF_FFFF);
        op(0, 1, 16'h0014, 0);
        check(bus_rdata == 32'h0, "R1 captured high after reset", 64'(bus_rdata), 64'h0);

        // R5 half loads, R6 coherent read, R2 carry
        op(1, 0, 16'h0014, 32'h0000_0001);
        op(1, 0, 16'h0010, 32'hFFFF_FFFE);
        op(0, 1, 16'h0010, 0);
        check(bus_rdata == 32'hFFFF_FFFE, "R5 low load", 64'(bus_rdata), 64'hFFFF_FFFE);
        op(0, 1, 16'h0014, 0);
        check(bus_rdata == 32'h1, "R6 captured high", 64'(bus_rdata), 64'h1);
        idle(2);
        op(0, 1, 16'h0010, 0);
        check(bus_rdata == 32'h2, "R2 carry low", 64'(bus_rdata), 64'h2);
        op(0, 1, 16'h0014, 0);
        check(bus_rdata == 32'h2, "R2 carry high", 64'(bus_rdata), 64'h2);

        // R3 freeze, R4 read-only fields
        op(1, 0, 16'h0000, 32'h1000_0000);
        op(0, 1, 16'h0010, 0);
        v1 = bus_rdata;
        idle(3);
        op(0, 1, 16'h0010, 0);
        check(bus_rdata == v1, "R3 frozen count", 64'(bus_rdata), 64'(v1));
        op(1, 0, 16'h0000, 32'hFFFF_FFFF);
        op(0, 1, 16'h0000, 0);
        check(bus_rdata == 32'h1818_0000, "R4 fields ignore write", 64'(bus_rdata), 64'h1818_0000);

        // R8 / R9 match and same-cycle clear
        op(1, 0, 16'h0014, 32'h0);
        op(1, 0, 16'h0010, 32'd50);
        op(1, 0, cmp_addr(0, 1), 32'h0);
        op(1, 0, cmp_addr(0, 0), 32'd40);
        check(irq[0] == 1'b0, "R9 low right after write", 64'(irq[0]), 64'h0);
        idle(1);
        check(irq[0] == 1'b1, "R8 rises on match", 64'(irq[0]), 64'h1);
        op(1, 0, cmp_addr(0, 0), 32'd30);
        check(irq[0] == 1'b0, "R9 write beats match", 64'(irq[0]), 64'h0);
        idle(1);
        check(irq[0] == 1'b1, "R9 re-raise", 64'(irq[0]), 64'h1);
        op(1, 0, 16'h0010, 32'd10);
        idle(2);
        check(irq[0] == 1'b1, "R8 sticky below compare", 64'(irq[0]), 64'h1);
        check(irq[1] == 1'b0, "R7 other context untouched", 64'(irq[1]), 64'h0);
        op(1, 0, cmp_addr(0, 0), 32'd100);
        idle(2);
        check(irq[0] == 1'b0, "R9 stays low when below", 64'(irq[0]), 64'h0);

        // R10 write and read together, R11 unmapped
        op(1, 1, 16'h0010, 32'd77);
        check(bus_rdata == 32'd10, "R10 read sees old value", 64'(bus_rdata), 64'd10);
        op(0, 1, 16'h0010, 0);
        check(bus_rdata == 32'd77, "R10 write wins", 64'(bus_rdata), 64'd77);
        op(0, 1, 16'h0020, 0);
        check(bus_rdata == 32'h0, "R11 unmapped read", 64'(bus_rdata), 64'h0);
        op(1, 0, 16'h0030, 32'hDEAD_BEEF);
        op(1, 0, 16'h80A8, 32'h0);
        op(0, 1, 16'h0010, 0);
        check(bus_rdata == 32'd77, "R11 unmapped write ignored", 64'(bus_rdata), 64'd77);
        op(0, 1, cmp_addr(0, 0), 0);
        check(bus_rdata == 32'd100, "R11 compare intact", 64'(bus_rdata), 64'd100);
        op(1, 0, 16'h0000, 32'h0);

        // random traffic checked by the model
        for (int i = 0; i < 3000; i++) begin
            int unsigned k = $urandom % 10;
            int          c = int'($urandom % NCTX);
            case (k)
                0, 1: op(0, 1, (($urandom % 2) != 0) ? 16'h0010 : 16'h0014, 0);
                2:    op(0, 1, cmp_addr(c, ($urandom % 2) != 0), 0);
                3:    op(0, 1, 16'h0000, 0);
                4:    op(1, ($urandom % 2) != 0, 16'h0010, m_cnt[31:0] - ($urandom % 64));
                5:    op(1, 0, cmp_addr(c, 0), m_cnt[31:0] + ($urandom % 24));
                6:    op(1, 0, cmp_addr(c, 1), m_cnt[63:32] + (($urandom % 4 == 0) ? 32'd1 : 32'd0));
                7:    op(1, 0, 16'h0000, (($urandom % 4) == 0) ? 32'h1000_0000 : 32'h0);
                default: idle(1);
            endcase
        end
        idle(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule